// File: doc/BRIEF.md
# Host Register Port with VRAM Pointer

This block is the slave end of an 8-bit parallel host bus on a graphics card. The host drives a 3-bit slot number, an active-low select and separate active-low read and write strobes. The block decodes one operation per select period. Slots 0 and 1 are passed straight through to the graphics controller's command and parameter port. Slot 2 holds the card configuration. Slots 4 to 7 load the two bytes of a 16-bit VRAM pointer. Slot 3 is a data window into VRAM at the pointer.

A window access becomes a request to the card's VRAM arbiter. The request stays up until the arbiter grants it. Only while a window request waits for a grant does the block pull its active-low WAIT output low. Read data is captured on the grant. When auto-increment is enabled, the pointer steps by one as the host releases select after a completed window access.

All host pins are sampled on the card clock. An operation starts on the first clock edge that sees select low and a strobe low.

Top module: `hostreg_port`

## Requirements
- R1: After reset, all four configuration outputs are 0, the VRAM pointer (`vram_addr_o`) is 0x0000, `host_wait_no` is high and `host_data_o` is 0x00.
- R2: A write to slot 0 or slot 1 gives exactly one `gdc_wr_o` pulse, with `gdc_a0_o` equal to slot bit 0 and `gdc_wdata_o` equal to the host byte. A read of slot 0 or 1 gives one `gdc_rd_o` pulse and returns `gdc_rdata_i` on `host_data_o`.
- R3: A write to slot 2 stores data bit 0 as auto-increment enable, bit 1 as wide mode, bit 2 as double-buffer enable and bit 7 as displayed-buffer select. Bits 3 to 6 have no effect on these outputs.
- R4: A write to slot 4 or slot 5 loads pointer bits 7:0. A write to slot 6 or slot 7 loads pointer bits 15:8.
- R5: A read of slot 2, 4, 5, 6 or 7 returns 0x00.
- R6: A slot-3 access raises `vram_req_o` with `vram_addr_o` equal to the pointer. For a write, `vram_we_o` is 1 and `vram_wdata_o` is the host byte; for a read, `vram_we_o` is 0. The request and address hold until `vram_gnt_i`, and exactly one granted cycle occurs per access.
- R7: `host_wait_no` is low only while a slot-3 request is pending without grant. It stays high for every other slot, even while the card is busy.
- R8: The VRAM byte present at the grant of a slot-3 read is returned on `host_data_o`. It is held for the rest of that select period even if `vram_rdata_i` changes.
- R9: With configuration bit 0 set, the pointer increments by one when select rises after a granted slot-3 access. With bit 0 clear, the pointer is unchanged.
- R10: An increment from 0xFFFF wraps the pointer to 0x0000.
- R11: Each select period performs at most one operation. Holding a strobe for many cycles, or releasing and reasserting it while select stays low, causes no second controller strobe and no second VRAM request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 3 | Slot number |
| host_data_i | input | 8 | Host write data |
| host_data_o | output | 8 | Host read data, 0 when not reading |
| host_sel_ni | input | 1 | Card select, active low |
| host_rd_ni | input | 1 | Read strobe, active low |
| host_wr_ni | input | 1 | Write strobe, active low |
| host_wait_no | output | 1 | Hold-off to the host, active low |
| gdc_wr_o | output | 1 | One-cycle write strobe to the controller |
| gdc_rd_o | output | 1 | One-cycle read strobe to the controller |
| gdc_a0_o | output | 1 | Controller command/parameter select |
| gdc_wdata_o | output | 8 | Data to the controller |
| gdc_rdata_i | input | 8 | Data from the controller |
| cfg_auto_inc_o | output | 1 | Pointer auto-increment enable |
| cfg_wide_o | output | 1 | Wide mode |
| cfg_dbuf_o | output | 1 | Automatic double buffering |
| cfg_disp_sel_o | output | 1 | Displayed buffer |
| vram_req_o | output | 1 | VRAM access request to the arbiter |
| vram_we_o | output | 1 | Request is a write |
| vram_addr_o | output | 16 | VRAM pointer |
| vram_wdata_o | output | 8 | VRAM write byte |
| vram_gnt_i | input | 1 | Arbiter grant |
| vram_rdata_i | input | 8 | VRAM read byte |

## Verification
The start of a window access and the arbiter grant can land in the same cycle. In that case the request is served with no hold-off at all, and WAIT must never be seen low. The bench provokes this by leaving the arbiter model idle. Otherwise it keeps the model busy for several cycles, so the start and the grant fall apart and WAIT has to drop and later recover. In both cases the granted request is judged against the expected address, direction and data in the scoreboard, along with the latched read byte and the pointer step.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
  typedef enum logic [2:0] {
    SLOT_CMD       = 3'd0,
    SLOT_PARAM     = 3'd1,
    SLOT_CFG       = 3'd2,
    SLOT_WIN       = 3'd3,
    SLOT_PLO       = 3'd4,
    SLOT_PLO_ALIAS = 3'd5,
    SLOT_PHI       = 3'd6,
    SLOT_PHI_ALIAS = 3'd7
  } slot_e;

  localparam int unsigned CFG_BIT_AUTOINC = 0;
  localparam int unsigned CFG_BIT_WIDE    = 1;
  localparam int unsigned CFG_BIT_DBUF    = 2;
  localparam int unsigned CFG_BIT_DISP    = 7;

  typedef struct packed {
    logic disp_sel;
    logic dbuf_en;
    logic wide_en;
    logic auto_inc;
  } cfg_t;
endpackage

// File: rtl/hostreg_access.sv
// One operation per select period; also reports the select release.
module hostreg_access (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_ni,
  input  logic rd_ni,
  input  logic wr_ni,
  output logic start_o,
  output logic is_wr_o,
  output logic sel_rise_o
);
  logic taken_q, sel_q;

  assign start_o    = ~sel_ni & (~rd_ni | ~wr_ni) & ~taken_q;
  assign is_wr_o    = ~wr_ni;
  assign sel_rise_o = sel_q & sel_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      sel_q   <= ~sel_ni;
      taken_q <= ~sel_ni & (taken_q | start_o);
    end
  end
endmodule

// File: rtl/hostreg_ptr.sv
module hostreg_ptr #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NBYTES = 2,
  localparam int unsigned ADDR_W = DATA_W * NBYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NBYTES-1:0] wr_byte_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (|wr_byte_i) begin
      for (int b = 0; b < int'(NBYTES); b++)
        if (wr_byte_i[b]) ptr_d[b*DATA_W +: DATA_W] = data_i;
    end else if (inc_i) begin
      ptr_d = ptr_q + 1'b1;  // wraps naturally
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/hostreg_win.sv
// VRAM data window: request until grant, hold-off, read capture.
module hostreg_win #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              is_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sel_rise_i,
  input  logic              gnt_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              req_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wait_no,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_rel_o
);
  logic              req_q, we_q, done_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic              grant;

  assign req_o      = start_i | req_q;
  assign we_o       = start_i ? is_wr_i : we_q;
  assign wdata_o    = start_i ? wdata_i : wd_q;
  assign grant      = req_o & gnt_i;
  assign wait_no    = ~(req_o & ~gnt_i);
  assign rdata_o    = rd_q;
  assign done_rel_o = sel_rise_i & done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      wd_q   <= '0;
      done_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (start_i) begin
        we_q <= is_wr_i;
        wd_q <= wdata_i;
      end
      if (sel_rise_i || grant) req_q <= 1'b0;
      else if (start_i)        req_q <= 1'b1;
      if (sel_rise_i)  done_q <= 1'b0;
      else if (grant)  done_q <= 1'b1;
      if (grant && !we_o) rd_q <= rdata_i;
    end
  end
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
  import hostreg_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        host_addr_i,
  input  logic [DATA_W-1:0] host_data_i,
  output logic [DATA_W-1:0] host_data_o,
  input  logic              host_sel_ni,
  input  logic              host_rd_ni,
  input  logic              host_wr_ni,
  output logic              host_wait_no,
  output logic              gdc_wr_o,
  output logic              gdc_rd_o,
  output logic              gdc_a0_o,
  output logic [DATA_W-1:0] gdc_wdata_o,
  input  logic [DATA_W-1:0] gdc_rdata_i,
  output logic              cfg_auto_inc_o,
  output logic              cfg_wide_o,
  output logic              cfg_dbuf_o,
  output logic              cfg_disp_sel_o,
  output logic              vram_req_o,
  output logic              vram_we_o,
  output logic [ADDR_W-1:0] vram_addr_o,
  output logic [DATA_W-1:0] vram_wdata_o,
  input  logic              vram_gnt_i,
  input  logic [DATA_W-1:0] vram_rdata_i
);
  localparam int unsigned NBYTES = ADDR_W / DATA_W;

  logic  start, is_wr, sel_rise;
  slot_e slot;
  logic  to_gdc, wr_op, rd_op, win_rel;
  logic [NBYTES-1:0] ptr_wr;
  logic [DATA_W-1:0] win_rdata;
  cfg_t  cfg_q;

  assign slot = slot_e'(host_addr_i);

  hostreg_access u_access (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_ni     (host_sel_ni),
    .rd_ni      (host_rd_ni),
    .wr_ni      (host_wr_ni),
    .start_o    (start),
    .is_wr_o    (is_wr),
    .sel_rise_o (sel_rise)
  );

  assign wr_op  = start & is_wr;
  assign rd_op  = start & ~is_wr;
  assign to_gdc = (slot == SLOT_CMD) || (slot == SLOT_PARAM);

  assign gdc_wr_o    = wr_op & to_gdc;
  assign gdc_rd_o    = rd_op & to_gdc;
  assign gdc_a0_o    = host_addr_i[0];
  assign gdc_wdata_o = host_data_i;

  // Configuration: reserved bits are not stored.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_op && slot == SLOT_CFG) begin
      cfg_q.auto_inc <= host_data_i[CFG_BIT_AUTOINC];
      cfg_q.wide_en  <= host_data_i[CFG_BIT_WIDE];
      cfg_q.dbuf_en  <= host_data_i[CFG_BIT_DBUF];
      cfg_q.disp_sel <= host_data_i[CFG_BIT_DISP];
    end
  end

  assign cfg_auto_inc_o = cfg_q.auto_inc;
  assign cfg_wide_o     = cfg_q.wide_en;
  assign cfg_dbuf_o     = cfg_q.dbuf_en;
  assign cfg_disp_sel_o = cfg_q.disp_sel;

  // Slots 4/5 hit byte 0, slots 6/7 hit byte 1.
  generate
    for (genvar b = 0; b < int'(NBYTES); b++) begin : g_ptr_sel
      assign ptr_wr[b] = wr_op && host_addr_i[2] && (int'(host_addr_i[1]) == b);
    end
  endgenerate

  hostreg_ptr #(.DATA_W(DATA_W), .NBYTES(NBYTES)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_byte_i (ptr_wr),
    .data_i    (host_data_i),
    .inc_i     (win_rel & cfg_q.auto_inc),
    .ptr_o     (vram_addr_o)
  );

  hostreg_win #(.DATA_W(DATA_W)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start && slot == SLOT_WIN),
    .is_wr_i    (is_wr),
    .wdata_i    (host_data_i),
    .sel_rise_i (sel_rise),
    .gnt_i      (vram_gnt_i),
    .rdata_i    (vram_rdata_i),
    .req_o      (vram_req_o),
    .we_o       (vram_we_o),
    .wdata_o    (vram_wdata_o),
    .wait_no    (host_wait_no),
    .rdata_o    (win_rdata),
    .done_rel_o (win_rel)
  );

  always_comb begin
    host_data_o = '0;
    if (!host_sel_ni && !host_rd_ni) begin
      unique case (slot)
        SLOT_CMD, SLOT_PARAM: host_data_o = gdc_rdata_i;
        SLOT_WIN:             host_data_o = win_rdata;
        default:              host_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/hostreg_port_chk.sv
module hostreg_port_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_sel_ni,
  input logic              host_wait_no,
  input logic              gdc_wr_o,
  input logic              gdc_rd_o,
  input logic              vram_req_o,
  input logic              vram_gnt_i,
  input logic [ADDR_W-1:0] vram_addr_o
);
  // R7
  a_r7_wait_only_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_wait_no |-> (vram_req_o && !vram_gnt_i));

  // R6
  a_r6_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vram_req_o && !vram_gnt_i && !host_sel_ni) |=> (vram_req_o && $stable(vram_addr_o)));

  // R2 / R11
  a_r2_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gdc_wr_o || gdc_rd_o) |=> !(gdc_wr_o || gdc_rd_o));

  a_r2_no_dual_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gdc_wr_o && gdc_rd_o));

  // R10: outside select the pointer only steps by one (with wrap)
  a_r10_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_sel_ni && $past(host_sel_ni) && (vram_addr_o != $past(vram_addr_o)))
      |-> (vram_addr_o == ADDR_W'($past(vram_addr_o) + 1'b1)));
endmodule

bind hostreg_port hostreg_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_sel_ni  (host_sel_ni),
  .host_wait_no (host_wait_no),
  .gdc_wr_o     (gdc_wr_o),
  .gdc_rd_o     (gdc_rd_o),
  .vram_req_o   (vram_req_o),
  .vram_gnt_i   (vram_gnt_i),
  .vram_addr_o  (vram_addr_o)
);

// File: tb/hostreg_port_test.sv
module hostreg_port_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [2:0]  host_addr;
  logic [7:0]  host_wdata, host_data_o;
  logic        host_sel_n, host_rd_n, host_wr_n, host_wait_no;
  logic        gdc_wr_o, gdc_rd_o, gdc_a0_o;
  logic [7:0]  gdc_wdata_o, gdc_rdata;
  logic        cfg_auto_inc_o, cfg_wide_o, cfg_dbuf_o, cfg_disp_sel_o;
  logic        vram_req_o, vram_we_o, vram_gnt_i;
  logic [15:0] vram_addr_o;
  logic [7:0]  vram_wdata_o, vram_rdata;
  logic        card_busy;

  assign vram_gnt_i = vram_req_o & ~card_busy;

  hostreg_port uut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_addr_i(host_addr), .host_data_i(host_wdata), .host_data_o(host_data_o),
    .host_sel_ni(host_sel_n), .host_rd_ni(host_rd_n), .host_wr_ni(host_wr_n),
    .host_wait_no(host_wait_no),
    .gdc_wr_o(gdc_wr_o), .gdc_rd_o(gdc_rd_o), .gdc_a0_o(gdc_a0_o),
    .gdc_wdata_o(gdc_wdata_o), .gdc_rdata_i(gdc_rdata),
    .cfg_auto_inc_o(cfg_auto_inc_o), .cfg_wide_o(cfg_wide_o),
    .cfg_dbuf_o(cfg_dbuf_o), .cfg_disp_sel_o(cfg_disp_sel_o),
    .vram_req_o(vram_req_o), .vram_we_o(vram_we_o), .vram_addr_o(vram_addr_o),
    .vram_wdata_o(vram_wdata_o), .vram_gnt_i(vram_gnt_i), .vram_rdata_i(vram_rdata)
  );

  int n_chk = 0, n_err = 0;
  logic [9:0]  gdc_q[$];   // {rd, a0, data}
  logic [24:0] vram_q[$];  // {we, addr, data}
  logic [15:0] exp_ptr;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitors: pop expected items as the design produces them.
  always @(negedge clk) begin
    if (rst_n) begin
      if (gdc_wr_o || gdc_rd_o) begin
        logic [9:0] got, want;
        got = {gdc_rd_o, gdc_a0_o, gdc_wdata_o};
        if (gdc_q.size() == 0) check(1'b0, "R2/R11 unexpected controller strobe", 32'(got), 0);
        else begin
          want = gdc_q.pop_front();
          check(got == want, "R2 controller strobe", 32'(got), 32'(want));
        end
      end
      if (vram_req_o && vram_gnt_i) begin
        logic [24:0] got, want;
        got = {vram_we_o, vram_addr_o, vram_wdata_o};
        if (vram_q.size() == 0) check(1'b0, "R6/R11 unexpected VRAM grant", 32'(got), 0);
        else begin
          want = vram_q.pop_front();
          check(got == want, "R6 VRAM request", 32'(got), 32'(want));
        end
      end
    end
  end

  task automatic access(input logic [2:0] a, input bit rd, input logic [7:0] d,
                        output logic [7:0] q, output bit saw_low);
    saw_low = 1'b0;
    @(posedge clk); #2;
    host_addr  = a;
    host_wdata = rd ? 8'h00 : d;
    host_sel_n = 1'b0;
    if (rd) host_rd_n = 1'b0; else host_wr_n = 1'b0;
    @(negedge clk);
    while (!host_wait_no) begin
      saw_low = 1'b1;
      @(negedge clk);
    end
    @(posedge clk); #1;
    vram_rdata = ~vram_rdata;  // must not disturb captured data (R8)
    @(negedge clk);
    q = host_data_o;
    @(posedge clk); #2;
    host_sel_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
    repeat (2) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] q; bit s;
    if (a < 3'd2) gdc_q.push_back({1'b0, a[0], d});
    if (a == 3'd3) vram_q.push_back({1'b1, exp_ptr, d});
    access(a, 1'b0, d, q, s);
  endtask

  initial begin
    logic [7:0] q;
    bit s;
    rst_n = 1'b0; host_addr = '0; host_wdata = '0;
    host_sel_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
    gdc_rdata = 8'hA5; vram_rdata = 8'h00; card_busy = 1'b0; exp_ptr = 16'h0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check({cfg_auto_inc_o, cfg_wide_o, cfg_dbuf_o, cfg_disp_sel_o} == 4'b0, "R1 cfg reset",
          32'({cfg_auto_inc_o, cfg_wide_o, cfg_dbuf_o, cfg_disp_sel_o}), 0);
    check(vram_addr_o == 16'h0, "R1 pointer reset", 32'(vram_addr_o), 0);
    check(host_wait_no == 1'b1, "R1 wait idle", 32'(host_wait_no), 1);
    check(host_data_o == 8'h00, "R1 data idle", 32'(host_data_o), 0);

    // R2 controller pass-through
    wr(3'd0, 8'h12);
    wr(3'd1, 8'h6F);
    gdc_q.push_back({1'b1, 1'b1, 8'h00});
    access(3'd1, 1'b1, 8'h00, q, s);
    check(q == 8'hA5, "R2 controller read data", 32'(q), 32'hA5);

    // R11 strobe toggled within one select period
    gdc_q.push_back({1'b0, 1'b0, 8'h21});
    @(posedge clk); #2;
    host_addr = 3'd0; host_wdata = 8'h21; host_sel_n = 1'b0; host_wr_n = 1'b0;
    repeat (3) @(posedge clk); #2 host_wr_n = 1'b1;
    repeat (2) @(posedge clk); #2 host_wr_n = 1'b0;
    repeat (3) @(posedge clk); #2 host_sel_n = 1'b1; host_wr_n = 1'b1;
    repeat (2) @(posedge clk); #2;
    check(gdc_q.size() == 0, "R11 single strobe per select", 32'(gdc_q.size()), 0);

    // R3 configuration
    wr(3'd2, 8'hFF);
    @(negedge clk);
    check({cfg_disp_sel_o, cfg_dbuf_o, cfg_wide_o, cfg_auto_inc_o} == 4'hF, "R3 cfg all set",
          32'({cfg_disp_sel_o, cfg_dbuf_o, cfg_wide_o, cfg_auto_inc_o}), 32'hF);
    wr(3'd2, 8'h78);
    @(negedge clk);
    check({cfg_disp_sel_o, cfg_dbuf_o, cfg_wide_o, cfg_auto_inc_o} == 4'h0, "R3 reserved bits only",
          32'({cfg_disp_sel_o, cfg_dbuf_o, cfg_wide_o, cfg_auto_inc_o}), 0);

    // R4 pointer bytes and aliases
    wr(3'd4, 8'h34); wr(3'd6, 8'h12);
    @(negedge clk);
    check(vram_addr_o == 16'h1234, "R4 pointer via 4/6", 32'(vram_addr_o), 32'h1234);
    wr(3'd5, 8'h56); wr(3'd7, 8'hAB);
    @(negedge clk);
    check(vram_addr_o == 16'hAB56, "R4 pointer via 5/7", 32'(vram_addr_o), 32'hAB56);
    exp_ptr = 16'hAB56;

    // R5 write-only slots read as zero
    for (int a = 2; a < 8; a++) begin
      if (a != 3) begin
        access(3'(a), 1'b1, 8'h00, q, s);
        check(q == 8'h00, $sformatf("R5 read slot %0d", a), 32'(q), 0);
      end
    end
    check(vram_addr_o == 16'hAB56, "R5 reads leave pointer", 32'(vram_addr_o), 32'hAB56);

    // R6/R9 window write, auto-increment off, idle arbiter (start and grant coincide)
    vram_q.push_back({1'b1, exp_ptr, 8'h9C});
    access(3'd3, 1'b0, 8'h9C, q, s);
    check(!s, "R7 no wait when arbiter idle", 32'(s), 0);
    @(negedge clk);
    check(vram_addr_o == 16'hAB56, "R9 no step when disabled", 32'(vram_addr_o), 32'hAB56);

    // R9 auto-increment on
    wr(3'd2, 8'h01);
    wr(3'd3, 8'h11);
    exp_ptr = exp_ptr + 1'b1;
    @(negedge clk);
    check(vram_addr_o == exp_ptr, "R9 step after write", 32'(vram_addr_o), 32'(exp_ptr));

    // R7 collision: WAIT drops while card is busy
    card_busy = 1'b1;
    vram_q.push_back({1'b1, exp_ptr, 8'h77});
    fork
      access(3'd3, 1'b0, 8'h77, q, s);
      begin repeat (6) @(posedge clk); #3 card_busy = 1'b0; end
    join
    check(s, "R7 wait low on collision", 32'(s), 1);
    exp_ptr = exp_ptr + 1'b1;
    @(negedge clk);
    check(vram_addr_o == exp_ptr, "R9 step after delayed grant", 32'(vram_addr_o), 32'(exp_ptr));

    // R7 other slots never wait while busy
    card_busy = 1'b1;
    gdc_q.push_back({1'b0, 1'b0, 8'h46});
    access(3'd0, 1'b0, 8'h46, q, s);
    check(!s, "R7 no wait for slot 0 while busy", 32'(s), 0);
    card_busy = 1'b0;

    // R8 read capture under collision
    vram_rdata = 8'h3C;
    card_busy = 1'b1;
    vram_q.push_back({1'b0, exp_ptr, 8'h00});
    fork
      access(3'd3, 1'b1, 8'h00, q, s);
      begin repeat (4) @(posedge clk); #3 card_busy = 1'b0; end
    join
    check(q == 8'h3C, "R8 captured read byte", 32'(q), 32'h3C);
    check(s, "R7 wait low during read collision", 32'(s), 1);
    exp_ptr = exp_ptr + 1'b1;

    // R10 wrap
    wr(3'd4, 8'hFF); wr(3'd6, 8'hFF);
    exp_ptr = 16'hFFFF;
    vram_rdata = 8'h5A;
    vram_q.push_back({1'b0, exp_ptr, 8'h00});
    access(3'd3, 1'b1, 8'h00, q, s);
    check(q == 8'h5A, "R8 read with idle arbiter", 32'(q), 32'h5A);
    @(negedge clk);
    check(vram_addr_o == 16'h0000, "R10 pointer wrap", 32'(vram_addr_o), 0);

    repeat (3) @(posedge clk);
    check(gdc_q.size() == 0, "R2 controller queue drained", 32'(gdc_q.size()), 0);
    check(vram_q.size() == 0, "R6 VRAM queue drained", 32'(vram_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule